// File: doc/BRIEF.md
# Boot Vector Bus Responder

A read-only slave that occupies the last 256 bytes of a 32-bit address space and answers every read there with one fixed 32-bit branch opcode, 0x4BFF7FE4. A processor that comes out of reset fetches from 0xFFFFFFFC, receives this opcode, and branches backwards to 0xFFFF7FE0, where the real boot code lives in some other memory. The block holds no storage of its own.

Instruction fetch after reset uses cacheline transactions. The responder therefore serves single-word reads and also whole four-word and eight-word line reads. Each line read delivers every beat, starting at the requested word and wrapping inside the line, and it drives the correct word index on each beat. A requester that gets fewer beats, or wrong word indices, would wait forever. Writes into the window are acknowledged and then dropped. The data path is 32 or 64 bits wide. In 64-bit mode, each lane of a beat carries the opcode.

Top module: `boot_vec_resp`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, addr_ack_o, rd_valid_o and rd_last_o are 0.
- R2: A request whose address lies in 0xFFFFFF00..0xFFFFFFFF and that is held while the block is idle gets addr_ack_o high in the next cycle, for one cycle. A request outside that window never gets an acknowledge.
- R3: A read with req_size_i = 0 returns one beat, in the cycle after the acknowledge. rd_word_o on that beat equals address bits [4:2].
- R4: A read with req_size_i = 1 (four-word line) returns four beats on consecutive cycles. On beat k, rd_word_o = {addr[4], (addr[3:2]+k) mod 4}.
- R5: A read with req_size_i = 2 (eight-word line) returns eight beats on consecutive cycles. On beat k, rd_word_o = (addr[4:2]+k) mod 8.
- R6: Every beat carries 0x4BFF7FE4 in every 32-bit lane of rd_data_o.
- R7: rd_last_o is high on the final beat of a transfer and on no other cycle.
- R8: A write (req_write_i = 1) in the window is acknowledged like a read, produces no data beat, and does not alter the data returned by later reads.
- R9: The reserved size code 3 is served exactly like a single-word read.
- R10: No request is acknowledged while an acknowledge or a data beat is in progress. A request still pending when the last beat ends is acknowledged in the second cycle after that last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; held until addr_ack_o |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address of the request |
| req_size_i | input | 2 | 0 word, 1 four-word line, 2 eight-word line, 3 reserved (word) |
| addr_ack_o | output | 1 | Request accepted |
| rd_valid_o | output | 1 | Data beat valid |
| rd_data_o | output | DW | Beat data |
| rd_word_o | output | 3 | 32-bit word index within the line for this beat |
| rd_last_o | output | 1 | Final beat of the transfer |

## Verification
Most faults in this block show up as a wrong beat sequence. A counter that ends early or late makes rd_last_o appear on the wrong beat, or the beats stop or run on, within one line time (at most eight cycles). A fault in the start-word or wrap arithmetic gives a wrong rd_word_o on the first beat that crosses the line boundary. A stuck state makes the next acknowledge arrive late or not at all. The bench covers every start position class and every size code, so each of these faults surfaces within a few cycles of the transfer that exposes it.

// File: rtl/bvr_pkg.sv
package bvr_pkg;
  typedef enum logic [1:0] {
    XFER_WORD  = 2'd0,
    XFER_LINE4 = 2'd1,
    XFER_LINE8 = 2'd2,
    XFER_RSVD  = 2'd3
  } xfer_e;

  localparam logic [31:0] BRANCH_WORD = 32'h4BFF7FE4;
  localparam int unsigned LINE_MAX    = 8;
  localparam int unsigned IDX_W       = $clog2(LINE_MAX);
endpackage

// File: rtl/bvr_decode.sv
module bvr_decode #(
  parameter logic [31:0] BASE     = 32'hFFFFFF00,
  parameter int unsigned WIN_BITS = 8
) (
  input  logic [31:0] addr_i,
  output logic        hit_o
);
  assign hit_o = (addr_i[31:WIN_BITS] == BASE[31:WIN_BITS]);
endmodule

// File: rtl/bvr_fill.sv
module bvr_fill #(
  parameter int unsigned DW = 32
) (
  output logic [DW-1:0] data_o
);
  localparam int unsigned LANES = DW / 32;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_o[l*32 +: 32] = bvr_pkg::BRANCH_WORD;
  end
endmodule

// File: rtl/bvr_seq.sv
module bvr_seq
  import bvr_pkg::*;
#(
  parameter int unsigned WPB = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             write_i,
  input  logic [1:0]       size_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             idle_o,
  output logic             ack_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] word_o,
  output logic             last_o
);
  localparam int unsigned LANE_SH = $clog2(WPB);
  localparam logic [IDX_W-1:0] LANE_M = IDX_W'(WPB - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_DATA} st_e;

  st_e              st_q;
  logic             wr_q;
  logic [IDX_W-1:0] start_q, mask_q, cnt_q, last_cnt_q;
  logic [IDX_W-1:0] mask_d;

  always_comb begin
    unique case (xfer_e'(size_i))
      XFER_LINE4: mask_d = IDX_W'(3);
      XFER_LINE8: mask_d = IDX_W'(7);
      default:    mask_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      wr_q       <= 1'b0;
      start_q    <= '0;
      mask_q     <= '0;
      cnt_q      <= '0;
      last_cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_i) begin
          st_q       <= ST_ACK;
          wr_q       <= write_i;
          start_q    <= start_i & ~LANE_M;
          mask_q     <= mask_d;
          last_cnt_q <= mask_d >> LANE_SH;
          cnt_q      <= '0;
        end
        ST_ACK:  st_q <= wr_q ? ST_IDLE : ST_DATA;
        ST_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == last_cnt_q) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // wrap within the line, keep the line-select bits above the mask
  logic [IDX_W-1:0] step;
  assign step    = cnt_q << LANE_SH;
  assign word_o  = (start_q & ~mask_q) | ((start_q + step) & mask_q);
  assign idle_o  = (st_q == ST_IDLE);
  assign ack_o   = (st_q == ST_ACK);
  assign valid_o = (st_q == ST_DATA);
  assign last_o  = valid_o && (cnt_q == last_cnt_q);
endmodule

// File: rtl/boot_vec_resp.sv
module boot_vec_resp
  import bvr_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter logic [31:0] BASE     = 32'hFFFFFF00,
  parameter int unsigned WIN_BITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [31:0]      req_addr_i,
  input  logic [1:0]       req_size_i,
  output logic             addr_ack_o,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic [IDX_W-1:0] rd_word_o,
  output logic             rd_last_o
);
  localparam int unsigned WPB = DW / 32;

  logic hit, idle, accept;

  bvr_decode #(.BASE(BASE), .WIN_BITS(WIN_BITS)) u_dec (
    .addr_i (req_addr_i),
    .hit_o  (hit)
  );

  assign accept = req_valid_i && hit && idle;

  bvr_seq #(.WPB(WPB)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .write_i  (req_write_i),
    .size_i   (req_size_i),
    .start_i  (req_addr_i[IDX_W+1:2]),
    .idle_o   (idle),
    .ack_o    (addr_ack_o),
    .valid_o  (rd_valid_o),
    .word_o   (rd_word_o),
    .last_o   (rd_last_o)
  );

  bvr_fill #(.DW(DW)) u_fill (
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/bvr_checker.sv
module bvr_checker
  import bvr_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter logic [31:0] BASE     = 32'hFFFFFF00,
  parameter int unsigned WIN_BITS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [31:0]      req_addr_i,
  input logic [1:0]       req_size_i,
  input logic             addr_ack_o,
  input logic             rd_valid_o,
  input logic [DW-1:0]    rd_data_o,
  input logic [IDX_W-1:0] rd_word_o,
  input logic             rd_last_o
);
  localparam int unsigned WPB = DW / 32;

  assert_ack_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_o |-> ($past(req_valid_i) &&
                    $past(req_addr_i[31:WIN_BITS]) == BASE[31:WIN_BITS]));

  assert_single_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_o |=> !addr_ack_o);

  assert_beat_const_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_data_o == {WPB{BRANCH_WORD}}));

  assert_last_in_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  assert_single_beat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(addr_ack_o) && $past(req_size_i, 2) == 2'd0) |-> rd_last_o);

  assert_write_no_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ack_o && $past(req_write_i)) |=> !rd_valid_o);

  assert_no_overlap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_o |-> !rd_valid_o);

  assert_beats_continue_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_last_o) |=> (rd_valid_o && !addr_ack_o));
endmodule

bind boot_vec_resp bvr_checker #(.DW(DW), .BASE(BASE), .WIN_BITS(WIN_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .addr_ack_o  (addr_ack_o),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .rd_word_o   (rd_word_o),
  .rd_last_o   (rd_last_o)
);

// File: tb/tb_boot_vec_resp.sv
module tb_boot_vec_resp;
  localparam int unsigned DW = 32;
  localparam logic [31:0] OPC = 32'h4BFF7FE4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        addr_ack, rd_valid, rd_last;
  logic [DW-1:0] rd_data;
  logic [2:0]  rd_word;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  boot_vec_resp #(.DW(DW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_size_i  (req_size),
    .addr_ack_o  (addr_ack),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data),
    .rd_word_o   (rd_word),
    .rd_last_o   (rd_last)
  );

  // {addr, size}
  localparam logic [33:0] VEC [0:7] = '{
    {32'hFFFFFFFC, 2'd2},
    {32'hFFFFFFFC, 2'd1},
    {32'hFFFFFF00, 2'd0},
    {32'hFFFFFF14, 2'd1},
    {32'hFFFFFF08, 2'd2},
    {32'hFFFFFFE0, 2'd3},
    {32'hFFFFFF30, 2'd2},
    {32'hFFFFFF9C, 2'd0}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int nbeats(input logic [1:0] sz);
    return (sz == 2'd1) ? 4 : (sz == 2'd2) ? 8 : 1;
  endfunction

  function automatic logic [2:0] exp_word(input logic [31:0] a, input logic [1:0] sz, input int k);
    logic [2:0] w;
    case (sz)
      2'd1:    w = {a[4], 2'(a[3:2] + k)};
      2'd2:    w = 3'(a[4:2] + k);
      default: w = a[4:2];
    endcase
    return w;
  endfunction

  function automatic string size_req(input logic [1:0] sz);
    case (sz)
      2'd1:    return "R4";
      2'd2:    return "R5";
      2'd3:    return "R9";
      default: return "R3";
    endcase
  endfunction

  task automatic read_xfer(input logic [31:0] a, input logic [1:0] sz);
    int nb;
    nb = nbeats(sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    chk(addr_ack == 1'b1, "R2 ack", 32'(addr_ack), 32'd1);
    chk(rd_valid == 1'b0, "R10 no beat during ack", 32'(rd_valid), 32'd0);
    req_valid = 1'b0;
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      chk(rd_valid == 1'b1, size_req(sz), 32'(rd_valid), 32'd1);
      chk(rd_data == OPC, "R6 data", rd_data, OPC);
      chk(rd_word == exp_word(a, sz, k), size_req(sz), 32'(rd_word), 32'(exp_word(a, sz, k)));
      chk(rd_last == (k == nb - 1), "R7 last", 32'(rd_last), 32'(k == nb - 1));
      chk(addr_ack == 1'b0, "R10 no ack in beats", 32'(addr_ack), 32'd0);
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, size_req(sz), 32'(rd_valid), 32'd0);
    chk(rd_last == 1'b0, "R7 last after end", 32'(rd_last), 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(!addr_ack && !rd_valid && !rd_last, "R1 in reset",
        {29'd0, addr_ack, rd_valid, rd_last}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!addr_ack && !rd_valid && !rd_last, "R1 after reset",
        {29'd0, addr_ack, rd_valid, rd_last}, 32'd0);

    for (int i = 0; i < 8; i++) read_xfer(VEC[i][33:2], VEC[i][1:0]);

    // R2: outside the window
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hFFFFFEFC; req_size = 2'd2;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(addr_ack == 1'b0, "R2 outside", 32'(addr_ack), 32'd0);
      chk(rd_valid == 1'b0, "R2 outside beat", 32'(rd_valid), 32'd0);
    end
    req_addr = 32'h7FFFFFFC;
    @(negedge clk);
    chk(addr_ack == 1'b0, "R2 outside low", 32'(addr_ack), 32'd0);
    req_valid = 1'b0;

    // R8: write acknowledged, no data
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'hFFFFFFFC; req_size = 2'd0;
    @(negedge clk);
    chk(addr_ack == 1'b1, "R8 write ack", 32'(addr_ack), 32'd1);
    req_valid = 1'b0; req_write = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(rd_valid == 1'b0, "R8 write no beat", 32'(rd_valid), 32'd0);
    end
    read_xfer(32'hFFFFFFFC, 2'd0);

    // R10: request raised during beats waits until the transfer ends
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hFFFFFF04; req_size = 2'd2;
    @(negedge clk);
    chk(addr_ack == 1'b1, "R10 first ack", 32'(addr_ack), 32'd1);
    req_addr = 32'hFFFFFF10; req_size = 2'd1; // kept high: second request
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(addr_ack == 1'b0, "R10 busy no ack", 32'(addr_ack), 32'd0);
      chk(rd_word == exp_word(32'hFFFFFF04, 2'd2, k), "R10 beat word",
          32'(rd_word), 32'(exp_word(32'hFFFFFF04, 2'd2, k)));
    end
    @(negedge clk);
    chk(addr_ack == 1'b0 && rd_valid == 1'b0, "R10 idle gap",
        {30'd0, addr_ack, rd_valid}, 32'd0);
    @(negedge clk);
    chk(addr_ack == 1'b1, "R10 pending ack", 32'(addr_ack), 32'd1);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rd_word == exp_word(32'hFFFFFF10, 2'd1, k), "R10 second xfer",
          32'(rd_word), 32'(exp_word(32'hFFFFFF10, 2'd1, k)));
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, "R7 end second xfer", 32'(rd_valid), 32'd0);

    finish_run();
  end
endmodule